// File: doc/BRIEF.md
# GF(2^163) Multiplicative Inverter

This block returns the multiplicative inverse of an element of the binary field GF(2^163). Each element is a 163-bit polynomial-basis word. The intended use is at the end of an elliptic-curve point multiplication, where coordinates held in projective form are turned back into affine form. That conversion takes one inversion per coordinate, so the block runs twice per point multiplication and accepts a new operand as soon as the previous result is out.

A one-cycle `start` strobe loads the operand. The block raises `busy` and then walks a fixed addition chain that uses only two operations:
- squarings, at one per clock, in a combinational squarer with fast reduction;
- multiplications, in a bit-serial shift-and-add multiplier that spends one clock per operand bit.

When the chain ends, the result is registered on `result` and `done` pulses for one cycle. The run time does not depend on the operand value. A zero operand gives a zero result.

Top module: `gf163_inverter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy` and `done` are low and `result` is zero.
- R2: A `start` pulse sampled while `busy` is low captures `operand`, and `busy` is high from the next cycle.
- R3: For a nonzero operand a, the returned value r satisfies r·a = 1 in GF(2)[x] modulo x^163 + x^7 + x^6 + x^3 + 1. Bit i of every word is the coefficient of x^i.
- R4: A zero operand gives a zero result.
- R5: `done` is high for exactly one cycle per accepted operand, and `busy` is low in that cycle. `result` changes only in a cycle where `done` is high, and it keeps its value until the next such cycle.
- R6: `done` rises exactly 1629 clock edges after the edge that accepted `start`, whatever the operand value.
- R7: A `start` pulse while `busy` is high has no effect. The running inversion keeps its operand and its timing.
- R8: A `start` presented in the cycle where `done` is high is accepted, so inversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to invert `operand` |
| operand | input | 163 | Field element to invert |
| busy | output | 1 | High while an inversion is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 163 | Inverse of the last accepted operand |

## Verification
A wrong entry in the chain table, a wrong operand choice for a chain step, or a corrupted intermediate value always changes the exponent that is computed. The product of result and operand is then not 1, and this shows up at the very first `done`, about 1629 cycles after `start`.

A miscounted squaring or bit index moves the `done` edge away from its fixed position, so a latency check catches it in the same operation. A state machine that reacts to a late `start` shows up either as an extra `done` pulse or as the result of the wrong operand.

// File: rtl/gf163_inverter.sv
module gf163_inverter (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [162:0] operand,
  output logic         busy,
  output logic         done,
  output logic [162:0] result
);
  localparam int M = 163;
  localparam int STEPS = 9;
  localparam logic [M-1:0] TAIL = M'(8'hC9);

  typedef enum logic [1:0] {S_IDLE, S_SQR, S_MUL, S_FIN} state_t;

  state_t       state;
  logic [M-1:0] a_q, acc, t, prod;
  logic [7:0]   cnt;
  logic [3:0]   step;

  function automatic logic [M-1:0] gf_sqr(input logic [M-1:0] x);
    logic [2*M-2:0] w;
    w = '0;
    for (int i = 0; i < M; i++) w[2*i] = x[i];
    for (int i = 2*M-2; i >= M; i--) begin
      if (w[i]) begin
        w[i]       = 1'b0;
        w[i-M]     = ~w[i-M];
        w[i-M+3]   = ~w[i-M+3];
        w[i-M+6]   = ~w[i-M+6];
        w[i-M+7]   = ~w[i-M+7];
      end
    end
    return w[M-1:0];
  endfunction

  function automatic logic [7:0] chain_j(input logic [3:0] s);
    case (s)
      4'd0: return 8'd1;
      4'd1: return 8'd2;
      4'd2: return 8'd1;
      4'd3: return 8'd5;
      4'd4: return 8'd10;
      4'd5: return 8'd20;
      4'd6: return 8'd40;
      4'd7: return 8'd1;
      default: return 8'd81;
    endcase
  endfunction

  wire          use_a   = (step == 4'd2) || (step == 4'd7);
  wire [M-1:0]  mop     = use_a ? a_q : acc;
  wire [M-1:0]  prod_nx = {prod[M-2:0], 1'b0} ^ (prod[M-1] ? TAIL : '0)
                        ^ (mop[cnt] ? t : '0);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      a_q    <= '0;
      acc    <= '0;
      t      <= '0;
      prod   <= '0;
      cnt    <= '0;
      step   <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          a_q   <= operand;
          acc   <= operand;
          t     <= operand;
          step  <= '0;
          cnt   <= chain_j(4'd0);
          state <= S_SQR;
        end
        S_SQR: begin
          t <= gf_sqr(t);
          if (cnt == 8'd1) begin
            cnt   <= 8'(M-1);
            prod  <= '0;
            state <= S_MUL;
          end else begin
            cnt <= cnt - 8'd1;
          end
        end
        S_MUL: begin
          prod <= prod_nx;
          if (cnt == 8'd0) begin
            acc <= prod_nx;
            t   <= prod_nx;
            if (step == 4'(STEPS-1)) begin
              state <= S_FIN;
            end else begin
              step  <= step + 4'd1;
              cnt   <= chain_j(step + 4'd1);
              state <= S_SQR;
            end
          end else begin
            cnt <= cnt - 8'd1;
          end
        end
        default: begin
          result <= gf_sqr(acc);
          done   <= 1'b1;
          state  <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module gf163_inverter_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [162:0] result
);
  localparam int LAT = 161 + 9*163 + 1;
  logic [11:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since <= '0;
    else if (start && !busy) since <= '0;
    else if (busy)           since <= since + 12'd1;
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R2
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since == 12'(LAT)));
endmodule

bind gf163_inverter gf163_inverter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .result(result)
);

// File: tb/gf163_inverter_bench.sv
module gf163_inverter_bench;
  localparam int LAT = 1629;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [162:0] operand = '0;
  wire          busy, done;
  wire  [162:0] result;

  gf163_inverter u_gf163_inverter (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [162:0] q_op[$];
  int           q_t[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [162:0] ref_mul(input logic [162:0] a, input logic [162:0] b);
    logic [324:0] c;
    logic [324:0] p;
    c = '0;
    for (int i = 0; i < 163; i++) if (b[i]) c = c ^ (325'(a) << i);
    p = (325'(1) << 163) | 325'h00C9;
    for (int i = 324; i >= 163; i--) if (c[i]) c = c ^ (p << (i - 163));
    return c[162:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [162:0] act, input logic [162:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [162:0] v);
    @(negedge clk);
    while (busy) @(negedge clk);
    operand = v;
    start = 1'b1;
    @(posedge clk);
    #1;
    q_op.push_back(v);
    q_t.push_back(cyc);
    start = 1'b0;
  endtask

  // scoreboard monitor
  always begin
    @(posedge clk);
    #1;
    if (done) begin
      if (q_op.size() == 0) begin
        chk(1'b0, "R5 done with no pending operand", 163'(1), 163'(0));
      end else begin
        logic [162:0] a;
        int t0;
        a = q_op.pop_front();
        t0 = q_t.pop_front();
        if (a == '0) chk(result == '0, "R4 zero operand", result, '0);
        else chk(ref_mul(result, a) == 163'(1), "R3 result*operand", ref_mul(result, a), 163'(1));
        chk(busy == 1'b0, "R5 busy low with done", 163'(busy), 163'(0));
        chk(cyc - t0 == LAT, "R6 latency", 163'(cyc - t0), 163'(LAT));
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [162:0] orig;
    logic [162:0] r_before;
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0, "R1 busy in reset", 163'(busy), 163'(0));
    chk(done == 1'b0, "R1 done in reset", 163'(done), 163'(0));
    chk(result == '0, "R1 result in reset", result, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after reset", result, '0);

    issue(163'(1));
    issue(163'(2));
    issue({163{1'b1}});
    issue(163'(0));

    // R2 and R7: start pulse while busy is ignored
    orig = 163'h5_A5A5_0F0F_1234_5678_9ABC_DEF0_1357_9BDF_2468_ACE0;
    issue(orig);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start", 163'(busy), 163'(1));
    r_before = result;
    repeat (50) @(negedge clk);
    operand = 163'h3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 still busy after ignored start", 163'(busy), 163'(1));
    chk(result == r_before, "R7 result unchanged mid-run", result, r_before);
    do @(negedge clk); while (!done);
    chk(ref_mul(result, orig) == 163'(1), "R7 inverse of original operand", ref_mul(result, orig), 163'(1));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 no second run", 163'({done, busy}), 163'(0));

    // R8: start presented in the done cycle
    issue(163'h7_0000_0000_0000_0000_0000_0000_0000_0000_0000_0001);
    do @(negedge clk); while (!done);
    operand = 163'h1_2345_6789;
    start = 1'b1;
    @(posedge clk);
    #1;
    q_op.push_back(163'h1_2345_6789);
    q_t.push_back(cyc);
    start = 1'b0;
    chk(busy == 1'b1, "R8 back-to-back start accepted", 163'(busy), 163'(1));

    for (int k = 0; k < 6; k++) begin
      logic [162:0] v;
      v = 163'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
      if (v == '0) v = 163'(1);
      issue(v);
    end

    while (q_op.size() != 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule